// File: doc/BRIEF.md
# HDLC Receive FIFO Frame Packer

The packer sits between an HDLC bit-level deframer and the host-facing receive FIFO. Each cycle the deframer may present one decoded byte, tagged as address, payload or checksum. At a frame boundary it presents an end strobe with the checksum verdict and an abort indication. The packer decides which bytes are stored and always writes the payload. Configuration bits can also let the first one or two address bytes and the two received checksum bytes into the FIFO. After the last data byte of each frame it appends one status byte. An automatic-handling mode turns off storage of address and checksum bytes, whatever the enables say.

A 2-bit threshold selects a block size of 32, 16, 4 or 2 bytes. A one-cycle interrupt pulse fires when the count of bytes written since the last host release reaches that size. A frame byte counter gives the number of bytes written for the current frame. A host release command frees a block. It also clears only those low bits of the frame counter that fall inside the current block size, so the host can still work out the total length from the bits that remain. The FIFO keeps one slot in reserve so that a frame which runs out of space can still report the overflow in its status byte.

Top module: `hdlc_rx_packer`

## Requirements
- R1: Payload bytes (kind code 0) are written to the FIFO in arrival order. The frame byte counter `frame_len` counts every byte written, including the status byte, and returns to 0 on `frame_start`.
- R2: With `addr_push_en`=1 and `auto_mode`=0, address bytes (kind code 1) are stored ahead of the payload. Only the first 1 (`addr_two`=0) or the first 2 (`addr_two`=1) of a frame are stored, and later address bytes are dropped.
- R3: With `crc_push_en`=1 and `auto_mode`=0, the first two checksum bytes (kind code 2) of a frame are stored after the payload, and further checksum bytes are dropped.
- R4: When `auto_mode`=1, or when the matching enable is 0, address and checksum bytes are never stored. Kind code 3 is never stored.
- R5: On `frame_end` one status byte is written: bit0 = `frame_crc_ok`, bit1 = `frame_abort`, bit2 = overflow in this frame, bits 7..3 = 0.
- R6: `rx_thresh` selects the block size: 0 gives 32, 1 gives 16, 2 gives 4 and 3 gives 2.
- R7: `pool_irq` is high for exactly one cycle, the cycle after the write that brings the count of bytes written since the last release to the block size. `rel_cmd` resets that count to 0.
- R8: `rel_cmd` clears `frame_len` bits 4..0, 3..0, 1..0 or bit 0 for thresholds 0, 1, 2 and 3. Higher bits are kept.
- R9: When `rel_cmd` and a write fall in the same cycle, the clear applies first and the write then adds one, to both `frame_len` and the release count.
- R10: A data byte is accepted only while the FIFO holds fewer than DEPTH-1 entries. Otherwise it is dropped, the overflow flag is set, and every further data byte of that frame is dropped. The status byte still uses the reserved slot.
- R11: After reset the FIFO is empty, `frame_len` is 0 and `pool_irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| auto_mode | input | 1 | Automatic handling: never store address or checksum |
| addr_push_en | input | 1 | Store address bytes |
| crc_push_en | input | 1 | Store received checksum bytes |
| addr_two | input | 1 | Address length: 0 = one byte, 1 = two bytes |
| rx_thresh | input | 2 | Block size select |
| frame_start | input | 1 | Start of a new frame (no byte in this cycle) |
| in_valid | input | 1 | Byte strobe from deframer |
| in_kind | input | 2 | 0 payload, 1 address, 2 checksum, 3 reserved |
| in_data | input | 8 | Received byte |
| frame_end | input | 1 | End of frame (no byte in this cycle) |
| frame_crc_ok | input | 1 | Checksum verdict, valid with frame_end |
| frame_abort | input | 1 | Abort indication, valid with frame_end |
| rel_cmd | input | 1 | Host release of one block |
| rd_en | input | 1 | FIFO read strobe |
| rd_data | output | 8 | FIFO head byte |
| rd_empty | output | 1 | FIFO empty |
| pool_irq | output | 1 | Block-full interrupt pulse |
| frame_len | output | CNT_W | Frame byte counter |

## Verification
A host release and a byte write can land in the same cycle, and both then act on the frame counter and on the release count. The bench drives `rel_cmd` together with a payload byte after a 7-byte run at block size 4. It expects `frame_len` to become 5, a clear followed by one increment, and it expects no interrupt, because the release count then restarts at 1. Separate runs check the clear alone at each threshold and the interrupt at each block size.

// File: rtl/hdlc_rx_pkg.sv
// Shared definitions for the HDLC receive packer.
// Assumes: byte kinds are coded on two bits by the deframer.
package hdlc_rx_pkg;

    typedef enum logic [1:0] {
        K_PAY  = 2'd0,
        K_ADDR = 2'd1,
        K_CRC  = 2'd2,
        K_RSVD = 2'd3
    } kind_e;

    // Low-bit mask of the block size chosen by the threshold code.
    function automatic logic [4:0] blk_mask(input logic [1:0] thr);
        case (thr)
            2'd0:    blk_mask = 5'h1F;
            2'd1:    blk_mask = 5'h0F;
            2'd2:    blk_mask = 5'h03;
            default: blk_mask = 5'h01;
        endcase
    endfunction

endpackage

// File: rtl/hdlc_rx_fifo.sv
// Synchronous byte FIFO with a show-ahead head and an occupancy count.
// Assumes: the writer never writes when full, and a read when empty is ignored.
module hdlc_rx_fifo #(
    parameter int DEPTH = 64,
    parameter int AW    = $clog2(DEPTH),
    parameter int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [7:0]       wr_data,
    input  logic             rd_en,
    output logic [7:0]       rd_data,
    output logic             empty,
    output logic [LVL_W-1:0] level
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [7:0]    mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic          do_rd;

    assign empty   = (level == '0);
    assign do_rd   = rd_en && !empty;
    assign rd_data = mem[rptr];

    // Storage array write port.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wptr] <= wr_data;
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            level <= '0;
        end else begin
            if (wr_en) wptr <= (wptr == LAST) ? '0 : wptr + 1'b1;
            if (do_rd) rptr <= (rptr == LAST) ? '0 : rptr + 1'b1;
            level <= level + LVL_W'(wr_en) - LVL_W'(do_rd);
        end
    end

    p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (level != LVL_W'(DEPTH)));

    p_empty_after_reset_r11: assert property (@(posedge clk)
        !rst_n |=> empty);

endmodule

// File: rtl/hdlc_rx_sel.sv
// Chooses which deframer bytes enter the FIFO and builds the status byte.
// Assumes: frame_start and frame_end never coincide with a byte strobe.
module hdlc_rx_sel #(
    parameter int DEPTH = 64,
    parameter int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             auto_mode,
    input  logic             addr_push_en,
    input  logic             crc_push_en,
    input  logic             addr_two,
    input  logic             frame_start,
    input  logic             in_valid,
    input  logic [1:0]       in_kind,
    input  logic [7:0]       in_data,
    input  logic             frame_end,
    input  logic             frame_crc_ok,
    input  logic             frame_abort,
    input  logic [LVL_W-1:0] fifo_level,
    output logic             wr_en,
    output logic [7:0]       wr_data
);
    import hdlc_rx_pkg::*;

    logic [1:0] addr_cnt, crc_cnt, addr_lim;
    logic       ovf, want_addr, want_crc, want, room_data, room_stat, take;

    // Byte acceptance decision and status byte assembly.
    always_comb begin
        addr_lim  = addr_two ? 2'd2 : 2'd1;
        want_addr = (in_kind == K_ADDR) && addr_push_en && !auto_mode && (addr_cnt < addr_lim);
        want_crc  = (in_kind == K_CRC) && crc_push_en && !auto_mode && (crc_cnt < 2'd2);
        want      = in_valid && ((in_kind == K_PAY) || want_addr || want_crc);
        room_data = fifo_level < LVL_W'(DEPTH - 1);
        room_stat = fifo_level < LVL_W'(DEPTH);
        take      = want && !ovf && room_data;
        wr_en     = frame_end ? room_stat : take;
        wr_data   = frame_end ? {5'b0, ovf, frame_abort, frame_crc_ok} : in_data;
    end

    // Per-frame address/checksum indices and overflow flag.
    always_ff @(posedge clk) begin
        if (!rst_n || frame_start || frame_end) begin
            addr_cnt <= '0;
            crc_cnt  <= '0;
            ovf      <= 1'b0;
        end else begin
            if (take && in_kind == K_ADDR) addr_cnt <= addr_cnt + 1'b1;
            if (take && in_kind == K_CRC)  crc_cnt  <= crc_cnt + 1'b1;
            if (want && !room_data)        ovf      <= 1'b1;
        end
    end

    p_auto_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !frame_end && auto_mode && in_kind != K_PAY) |-> !wr_en);

    p_drop_after_ovf_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && in_valid && !frame_end) |-> !wr_en);

    p_addr_limit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        addr_cnt <= 2'd2);

endmodule

// File: rtl/hdlc_rx_cnt.sv
// Frame byte counter, release count and block-full interrupt.
// Assumes: wr reports every byte actually written to the FIFO.
module hdlc_rx_cnt #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic             frame_start,
    input  logic             rel_cmd,
    input  logic [1:0]       rx_thresh,
    output logic [CNT_W-1:0] frame_len,
    output logic             pool_irq
);
    import hdlc_rx_pkg::*;

    logic [CNT_W-1:0] clr_mask, bsize, unrel, unrel_nxt;

    // Next release count and block size from the threshold.
    always_comb begin
        clr_mask  = CNT_W'(blk_mask(rx_thresh));
        bsize     = clr_mask + 1'b1;
        unrel_nxt = (rel_cmd ? '0 : unrel) + CNT_W'(wr);
    end

    // Counter registers and the one-cycle interrupt.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_len <= '0;
            unrel     <= '0;
            pool_irq  <= 1'b0;
        end else begin
            unrel    <= unrel_nxt;
            pool_irq <= wr && (unrel_nxt == bsize);
            if (frame_start)
                frame_len <= '0;
            else
                frame_len <= (rel_cmd ? (frame_len & ~clr_mask) : frame_len) + CNT_W'(wr);
        end
    end

    p_irq_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pool_irq |=> !pool_irq);

    p_start_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (frame_len == '0));

    p_rel_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_cmd && !frame_start && !wr) |=> ((frame_len & $past(clr_mask)) == '0));

endmodule

// File: rtl/hdlc_rx_packer.sv
// Top: byte selection, FIFO storage and length/interrupt counting.
// Assumes: one deframer event per cycle; host reads through rd_en/rd_data.
module hdlc_rx_packer #(
    parameter int DEPTH = 64,
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             auto_mode,
    input  logic             addr_push_en,
    input  logic             crc_push_en,
    input  logic             addr_two,
    input  logic [1:0]       rx_thresh,
    input  logic             frame_start,
    input  logic             in_valid,
    input  logic [1:0]       in_kind,
    input  logic [7:0]       in_data,
    input  logic             frame_end,
    input  logic             frame_crc_ok,
    input  logic             frame_abort,
    input  logic             rel_cmd,
    input  logic             rd_en,
    output logic [7:0]       rd_data,
    output logic             rd_empty,
    output logic             pool_irq,
    output logic [CNT_W-1:0] frame_len
);
    localparam int AW    = $clog2(DEPTH);
    localparam int LVL_W = $clog2(DEPTH + 1);

    logic             wr_en;
    logic [7:0]       wr_data;
    logic [LVL_W-1:0] level;

    hdlc_rx_sel #(.DEPTH(DEPTH), .LVL_W(LVL_W)) sel_i (
        .clk(clk), .rst_n(rst_n), .auto_mode(auto_mode),
        .addr_push_en(addr_push_en), .crc_push_en(crc_push_en), .addr_two(addr_two),
        .frame_start(frame_start), .in_valid(in_valid), .in_kind(in_kind),
        .in_data(in_data), .frame_end(frame_end), .frame_crc_ok(frame_crc_ok),
        .frame_abort(frame_abort), .fifo_level(level), .wr_en(wr_en), .wr_data(wr_data)
    );

    hdlc_rx_fifo #(.DEPTH(DEPTH), .AW(AW), .LVL_W(LVL_W)) fifo_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .empty(rd_empty), .level(level)
    );

    hdlc_rx_cnt #(.CNT_W(CNT_W)) cnt_i (
        .clk(clk), .rst_n(rst_n), .wr(wr_en), .frame_start(frame_start),
        .rel_cmd(rel_cmd), .rx_thresh(rx_thresh), .frame_len(frame_len),
        .pool_irq(pool_irq)
    );

endmodule

// File: tb/hdlc_rx_packer_tb.sv
// Bench: table of frame configurations, then directed threshold,
// release, same-cycle and overflow tests.
module hdlc_rx_packer_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 64;
    localparam int CNT_W = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic auto_mode = 0, addr_push_en = 0, crc_push_en = 0, addr_two = 0;
    logic [1:0] rx_thresh = 2'd0;
    logic frame_start = 0, in_valid = 0, frame_end = 0, frame_crc_ok = 0, frame_abort = 0;
    logic [1:0] in_kind = 2'd0;
    logic [7:0] in_data = 8'h00;
    logic rel_cmd = 0, rd_en = 0;
    logic [7:0] rd_data;
    logic rd_empty, pool_irq;
    logic [CNT_W-1:0] frame_len;

    int n_chk = 0, n_err = 0;
    logic [7:0] exp_buf [80];
    int exp_n;

    // {auto, addr_en, crc_en, two, crc_ok, abort, n_payload[3:0], exp_len[7:0]}
    localparam logic [17:0] VEC [6] = '{
        {6'b011110, 4'd3, 8'd8},
        {6'b010000, 4'd2, 8'd4},
        {6'b111110, 4'd4, 8'd5},
        {6'b001011, 4'd1, 8'd4},
        {6'b000000, 4'd0, 8'd1},
        {6'b011010, 4'd5, 8'd9}
    };

    hdlc_rx_packer #(.DEPTH(DEPTH), .CNT_W(CNT_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .auto_mode(auto_mode), .addr_push_en(addr_push_en),
        .crc_push_en(crc_push_en), .addr_two(addr_two), .rx_thresh(rx_thresh),
        .frame_start(frame_start), .in_valid(in_valid), .in_kind(in_kind),
        .in_data(in_data), .frame_end(frame_end), .frame_crc_ok(frame_crc_ok),
        .frame_abort(frame_abort), .rel_cmd(rel_cmd), .rd_en(rd_en),
        .rd_data(rd_data), .rd_empty(rd_empty), .pool_irq(pool_irq), .frame_len(frame_len)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic put(input logic [1:0] k, input logic [7:0] d);
        in_valid = 1; in_kind = k; in_data = d;
        tick();
        in_valid = 0;
    endtask

    task automatic start_frame();
        frame_start = 1; tick(); frame_start = 0;
    endtask

    task automatic end_frame(input logic ok, input logic ab);
        frame_end = 1; frame_crc_ok = ok; frame_abort = ab;
        tick();
        frame_end = 0; frame_crc_ok = 0; frame_abort = 0;
    endtask

    task automatic release_blk();
        rel_cmd = 1; tick(); rel_cmd = 0;
    endtask

    task automatic drain_all();
        while (!rd_empty) begin
            rd_en = 1; tick(); rd_en = 0;
        end
    endtask

    task automatic rel_case(input logic [1:0] t, input int n, input int exp);
        rx_thresh = t;
        start_frame();
        for (int k = 0; k < n; k++) put(2'd0, 8'(k));
        release_blk();
        chk("R8 release clears low bits", int'(frame_len), exp);
        end_frame(1'b1, 1'b0);
        drain_all();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (3) tick();
        rst_n = 1;
        tick();
        // R11 reset state
        chk("R11 empty", int'(rd_empty), 1);
        chk("R11 frame_len", int'(frame_len), 0);
        chk("R11 pool_irq", int'(pool_irq), 0);

        // R1 R2 R3 R4 R5: configuration table
        for (int i = 0; i < 6; i++) begin
            logic [17:0] v;
            v = VEC[i];
            auto_mode = v[17]; addr_push_en = v[16]; crc_push_en = v[15]; addr_two = v[14];
            exp_n = 0;
            start_frame();
            for (int a = 0; a < 3; a++) begin
                put(2'd1, 8'(8'hA0 + a));
                if (!v[17] && v[16] && a < (v[14] ? 2 : 1)) exp_buf[exp_n++] = 8'(8'hA0 + a);
            end
            for (int p = 0; p < int'(v[11:8]); p++) begin
                put(2'd0, 8'(8'h10 + p));
                exp_buf[exp_n++] = 8'(8'h10 + p);
            end
            for (int c = 0; c < 3; c++) begin
                put(2'd2, 8'(8'hC0 + c));
                if (!v[17] && v[15] && c < 2) exp_buf[exp_n++] = 8'(8'hC0 + c);
            end
            put(2'd3, 8'hEE);
            end_frame(v[13], v[12]);
            exp_buf[exp_n++] = {5'b0, 1'b0, v[12], v[13]};
            chk("R1 frame_len after frame", int'(frame_len), int'(v[7:0]));
            for (int j = 0; j < exp_n; j++) begin
                chk("R1 R2 R3 R4 R5 FIFO byte", int'(rd_data), int'(exp_buf[j]));
                rd_en = 1; tick(); rd_en = 0;
            end
            chk("R4 no extra bytes stored", int'(rd_empty), 1);
        end
        auto_mode = 0; addr_push_en = 0; crc_push_en = 0; addr_two = 0;

        // R6 R7: interrupt at each block size
        for (int t = 0; t < 4; t++) begin
            int bs;
            bs = (t == 0) ? 32 : (t == 1) ? 16 : (t == 2) ? 4 : 2;
            rx_thresh = 2'(t);
            release_blk();
            start_frame();
            for (int k = 1; k <= bs; k++) begin
                put(2'd0, 8'(k));
                chk("R6 R7 pool_irq at block size", int'(pool_irq), (k == bs) ? 1 : 0);
            end
            put(2'd0, 8'h55);
            chk("R7 one-cycle pulse", int'(pool_irq), 0);
            end_frame(1'b0, 1'b0);
            drain_all();
        end

        // R8 release clear per threshold
        rel_case(2'd0, 7, 0);
        rel_case(2'd3, 7, 6);
        rel_case(2'd2, 7, 4);
        rel_case(2'd1, 19, 16);
        rel_case(2'd1, 13, 0);

        // R9 release and write in the same cycle
        rx_thresh = 2'd2;
        release_blk();
        start_frame();
        for (int k = 0; k < 7; k++) put(2'd0, 8'(k));
        rel_cmd = 1; in_valid = 1; in_kind = 2'd0; in_data = 8'h77;
        tick();
        rel_cmd = 0; in_valid = 0;
        chk("R9 clear then increment", int'(frame_len), 5);
        chk("R9 release count restarts", int'(pool_irq), 0);
        put(2'd0, 8'h78);
        chk("R9 no irq at count 2", int'(pool_irq), 0);
        end_frame(1'b1, 1'b0);
        drain_all();

        // R10 overflow with reserved status slot
        rx_thresh = 2'd0;
        start_frame();
        for (int k = 0; k < 70; k++) put(2'd0, 8'(k));
        end_frame(1'b1, 1'b0);
        chk("R10 frame_len with overflow", int'(frame_len), DEPTH);
        for (int j = 0; j < DEPTH - 1; j++) begin
            chk("R10 kept byte", int'(rd_data), j);
            rd_en = 1; tick(); rd_en = 0;
        end
        chk("R10 R5 overflow status", int'(rd_data), 8'h05);
        rd_en = 1; tick(); rd_en = 0;
        chk("R10 FIFO empty after drain", int'(rd_empty), 1);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule